// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block resolves a physical address to the DRAM chip-select row that holds it. Software loads one small boundary register per row through a simple write port. Each register holds the cumulative upper limit of its row in 64 MiB units. A row therefore covers the span from the previous row's limit up to one unit below its own limit. A row whose limit does not rise above the previous one holds no memory.

The lookup is purely combinational. It takes the current register contents, a channel-mode input and the lookup address, and returns three things: a hit flag, the index of the matching row, and a mask of the rows that hold memory. In single-channel mode all eight rows take part. In dual-channel mode only the lower four rows do.

Top module: `rbd_decoder`

## Requirements
- R1: While reset is asserted, and after it until the first write, every boundary register is zero. The populated mask is 0, the hit flag is 0 and the row index is 0 for any address and either mode.
- R2: A write with `wr_en` high stores `wr_data[6:0]` into the register selected by `wr_idx` at the rising clock edge. Bit 7 of `wr_data` is reserved and has no effect on the decode.
- R3: The address is compared in 64 MiB units, that is as `lookup_addr >> 26`. The low 26 address bits never change the result.
- R4: Row r matches unit u when lower(r) <= u < boundary(r). Here lower(0) is 0, and lower(r) is the boundary of row r-1 for r > 0.
- R5: Row r is populated, and its bit in `row_populated` is set, only when its boundary is strictly greater than lower(r). A row that is not populated never matches.
- R6: With `dual_mode` = 0, rows 0 to 7 are active. With `dual_mode` = 1, only rows 0 to 3 are active: bits 7:4 of `row_populated` read 0 and rows 4 to 7 never match.
- R7: An address at or above the last active boundary gives `row_hit` = 0 and `row_idx` = 0.
- R8: When several active rows match, the lowest-numbered one is reported.
- R9: The outputs follow `lookup_addr` and `dual_mode` in the same cycle. A register write becomes visible in the lookup only after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the boundary registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Boundary register write strobe |
| wr_idx | input | 3 | Row whose boundary is written |
| wr_data | input | 8 | Write data; bits 6:0 are the boundary, bit 7 is reserved |
| dual_mode | input | 1 | 0 = single channel (8 rows), 1 = dual channel (4 rows) |
| lookup_addr | input | 32 | Physical address to decode |
| row_idx | output | 3 | Matching row, 0 on a miss |
| row_hit | output | 1 | An active populated row contains the address |
| row_populated | output | 8 | Per-row populated mask, active rows only |

## Verification
A boundary write and a lookup can fall in the same cycle. The sharp case is a write to the row that the lookup address would land in. The bench holds an address just beyond the current total size. It then raises a write that extends the last row to cover that address. The outputs are sampled in the low phase before the storing edge, where a miss is expected, and again after that edge, where a hit on the last row is expected. A second overlap comes from toggling `dual_mode` under a fixed address in a rows-4-to-7 region. The hit must vanish within the same cycle, with no clock edge involved.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

   typedef enum logic {
      CH_SINGLE = 1'b0,
      CH_DUAL   = 1'b1
   } ch_mode_e;

   // number of rows that take part in a lookup for a channel mode
   function automatic int unsigned active_rows(input ch_mode_e mode, input int unsigned total);
      return (mode == CH_DUAL) ? total / 2 : total;
   endfunction

endpackage

// File: rtl/rbd_bound_regs.sv
module rbd_bound_regs #(
   parameter int unsigned NUM_ROWS = 8,
   parameter int unsigned REG_W    = 8,
   parameter int unsigned BND_W    = 7,
   parameter int unsigned IDX_W    = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  logic [REG_W-1:0]                 wr_data,
   output logic [NUM_ROWS-1:0][BND_W-1:0]   bnd_o
);

   logic [NUM_ROWS-1:0][BND_W-1:0] bnd_q;
   logic                           rsvd_unused;

   generate
      if (REG_W > BND_W) begin : g_rsvd
         assign rsvd_unused = ^wr_data[REG_W-1:BND_W];
      end else begin : g_no_rsvd
         assign rsvd_unused = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bnd_q <= '0;
      end else if (wr_en) begin
         bnd_q[wr_idx] <= wr_data[BND_W-1:0];
      end
   end

   assign bnd_o = bnd_q;

   // R2
   wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> bnd_o[$past(wr_idx)] == $past(wr_data[BND_W-1:0]));

   // R9
   no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(bnd_o));

endmodule

// File: rtl/rbd_row_match.sv
module rbd_row_match #(
   parameter int unsigned BND_W = 7
) (
   input  logic [BND_W-1:0] lower,
   input  logic [BND_W-1:0] upper,
   input  logic [BND_W-1:0] unit_i,
   input  logic             active,
   output logic             populated,
   output logic             match
);

   logic above_floor;
   logic below_ceil;

   always_comb begin
      above_floor = (unit_i >= lower);
      below_ceil  = (unit_i <  upper);
      populated   = active && (upper > lower);
      match       = populated && above_floor && below_ceil;
   end

endmodule

// File: rtl/rbd_prio_enc.sv
module rbd_prio_enc #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = IDX_W'(i);
            any = 1'b1;
         end
      end
   end

   // R8
   prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));

endmodule

// File: rtl/rbd_decoder.sv
module rbd_decoder #(
   parameter int unsigned NUM_ROWS   = 8,
   parameter int unsigned REG_W      = 8,
   parameter int unsigned BND_W      = 7,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned UNIT_SHIFT = 26,
   parameter int unsigned IDX_W      = $clog2(NUM_ROWS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [REG_W-1:0]    wr_data,
   input  logic                dual_mode,
   input  logic [ADDR_W-1:0]   lookup_addr,
   output logic [IDX_W-1:0]    row_idx,
   output logic                row_hit,
   output logic [NUM_ROWS-1:0] row_populated
);
   import rbd_pkg::*;

   localparam int unsigned UNIT_W    = ADDR_W - UNIT_SHIFT;
   localparam int unsigned DUAL_ROWS = NUM_ROWS / 2;

   generate
      if (NUM_ROWS != (1 << IDX_W)) begin : g_bad_rows
         $error("NUM_ROWS must be a power of two matching IDX_W");
      end
      if (UNIT_W > BND_W || UNIT_W == 0) begin : g_bad_unit
         $error("address unit index must fit the boundary field");
      end
      if (BND_W > REG_W) begin : g_bad_field
         $error("boundary field wider than register");
      end
   endgenerate

   ch_mode_e                       mode;
   logic [NUM_ROWS-1:0][BND_W-1:0] bnd;
   logic [BND_W-1:0]               unit_ext;
   logic [NUM_ROWS-1:0]            match_vec;
   logic [NUM_ROWS-1:0]            pop_vec;
   logic [NUM_ROWS-1:0]            act_vec;
   logic                           addr_unused;

   assign mode        = ch_mode_e'(dual_mode);
   assign unit_ext    = BND_W'(lookup_addr[ADDR_W-1:UNIT_SHIFT]);
   assign addr_unused = ^lookup_addr[UNIT_SHIFT-1:0];

   rbd_bound_regs #(
      .NUM_ROWS (NUM_ROWS),
      .REG_W    (REG_W),
      .BND_W    (BND_W),
      .IDX_W    (IDX_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .bnd_o   (bnd)
   );

   generate
      for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
         logic [BND_W-1:0] lo;
         if (r == 0) begin : g_first
            assign lo = '0;
         end else begin : g_next
            assign lo = bnd[r-1];
         end

         if (r < DUAL_ROWS) begin : g_always_on
            assign act_vec[r] = 1'b1;
         end else begin : g_single_only
            assign act_vec[r] = (mode == CH_SINGLE);
         end

         rbd_row_match #(
            .BND_W (BND_W)
         ) u_match (
            .lower     (lo),
            .upper     (bnd[r]),
            .unit_i    (unit_ext),
            .active    (act_vec[r]),
            .populated (pop_vec[r]),
            .match     (match_vec[r])
         );
      end
   endgenerate

   rbd_prio_enc #(
      .N     (NUM_ROWS),
      .IDX_W (IDX_W)
   ) u_prio (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (match_vec),
      .idx   (row_idx),
      .any   (row_hit)
   );

   assign row_populated = pop_vec;

   // R5
   hit_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_hit |-> row_populated[row_idx]);

   // R7
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !row_hit |-> (row_idx == '0));

   // R6
   dual_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dual_mode |-> (row_populated[NUM_ROWS-1:DUAL_ROWS] == '0));

   // R6
   dual_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dual_mode && row_hit) |-> (int'(row_idx) < DUAL_ROWS));

endmodule

// File: tb/rbd_decoder_tb.sv
module rbd_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [2:0]  wr_idx;
   logic [7:0]  wr_data;
   logic        dual_mode;
   logic [31:0] lookup_addr;
   logic [2:0]  row_idx;
   logic        row_hit;
   logic [7:0]  row_populated;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;

   rbd_decoder u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_idx        (wr_idx),
      .wr_data       (wr_data),
      .dual_mode     (dual_mode),
      .lookup_addr   (lookup_addr),
      .row_idx       (row_idx),
      .row_hit       (row_hit),
      .row_populated (row_populated)
   );

   // {dual, addr, hit, idx}; boundaries 2,4,4,8,10,10,12,20 units
   localparam logic [36:0] VEC [0:13] = '{
      {1'b0, 32'h0000_0000, 1'b1, 3'd0},   // R4 row 0 base
      {1'b0, 32'h07FF_FFFF, 1'b1, 3'd0},   // R3 top byte of unit 1
      {1'b0, 32'h0800_0000, 1'b1, 3'd1},   // R4 row 1 base
      {1'b0, 32'h1000_0000, 1'b1, 3'd3},   // R5 empty row 2 skipped
      {1'b0, 32'h1C00_0123, 1'b1, 3'd3},   // R3 offset ignored
      {1'b0, 32'h2000_0000, 1'b1, 3'd4},
      {1'b0, 32'h2800_0000, 1'b1, 3'd6},   // R5 empty row 5 skipped
      {1'b0, 32'h4C00_0000, 1'b1, 3'd7},
      {1'b0, 32'h5000_0000, 1'b0, 3'd0},   // R7 at total size
      {1'b0, 32'hFFFF_FFFF, 1'b0, 3'd0},   // R7
      {1'b1, 32'h1400_0000, 1'b1, 3'd3},   // R6 dual row 3
      {1'b1, 32'h2000_0000, 1'b0, 3'd0},   // R6 dual beyond row 3
      {1'b1, 32'h3000_0000, 1'b0, 3'd0},   // R6 R7
      {1'b1, 32'h0400_0000, 1'b1, 3'd0}
   };

   task automatic chk_lookup(input string req, input logic eh, input logic [2:0] ei);
      n_checks++;
      if (row_hit !== eh || row_idx !== ei) begin
         n_errors++;
         $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", req, row_hit, row_idx, eh, ei);
      end
   endtask

   task automatic chk_mask(input string req, input logic [7:0] em);
      n_checks++;
      if (row_populated !== em) begin
         n_errors++;
         $display("FAIL %s: mask=%h expected %h", req, row_populated, em);
      end
   endtask

   task automatic look(input logic d, input logic [31:0] a);
      dual_mode   = d;
      lookup_addr = a;
      #1;
   endtask

   task automatic wr(input logic [2:0] i, input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = i; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   initial begin
      #(200000 * 8);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not end, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
      dual_mode = 1'b0; lookup_addr = '0;
      repeat (3) @(negedge clk);
      look(0, 32'h0);
      chk_lookup("R1 reset addr0", 1'b0, 3'd0);
      chk_mask("R1 reset mask", 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      look(1, 32'hFFFF_FFFF);
      chk_lookup("R1 after reset", 1'b0, 3'd0);
      chk_mask("R1 after reset mask", 8'h00);

      wr(0, 8'd2);  wr(1, 8'd4);  wr(2, 8'd4);  wr(3, 8'd8);
      wr(4, 8'd10); wr(5, 8'd10); wr(6, 8'd12); wr(7, 8'd20);
      look(0, 32'h0);
      chk_mask("R5 single mask", 8'hDB);
      look(1, 32'h0);
      chk_mask("R6 dual mask", 8'h0B);

      for (int k = 0; k < 14; k++) begin
         look(VEC[k][36], VEC[k][35:4]);
         chk_lookup($sformatf("R4 table %0d", k), VEC[k][3], VEC[k][2:0]);
      end

      // R2: reserved bit 7 must not widen row 0
      wr(0, 8'h82);
      look(0, 32'h0C00_0000);
      chk_lookup("R2 reserved bit", 1'b1, 3'd1);
      wr(0, 8'd2);

      // R8: row 3 lower drops to 1, overlapping rows 0 and 1
      wr(2, 8'd1);
      look(0, 32'h0800_0000);
      chk_lookup("R8 row1 over row3", 1'b1, 3'd1);
      look(0, 32'h0400_0000);
      chk_lookup("R8 row0 over row3", 1'b1, 3'd0);
      look(0, 32'h1400_0000);
      chk_lookup("R8 row3 alone", 1'b1, 3'd3);
      chk_mask("R5 non-rising row empty", 8'hDB);
      wr(2, 8'd4);

      // R9: write and lookup in the same cycle
      look(0, 32'h5800_0000);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 3'd7; wr_data = 8'd24;
      #1;
      chk_lookup("R9 before store edge", 1'b0, 3'd0);
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      chk_lookup("R9 after store edge", 1'b1, 3'd7);

      // R9 / R6: mode switch acts without a clock edge
      look(0, 32'h2400_0000);
      chk_lookup("R6 single row 4", 1'b1, 3'd4);
      look(1, 32'h2400_0000);
      chk_lookup("R9 dual same cycle", 1'b0, 3'd0);

      // R1: reset mid-run clears everything
      rst_n = 1'b0;
      #1;
      look(0, 32'h0);
      chk_lookup("R1 mid-run reset", 1'b0, 3'd0);
      chk_mask("R1 mid-run reset mask", 8'h00);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule